// File: doc/BRIEF.md
# Serial Control Port with Interface Latches

This block is the configuration front end of a mixed-signal channel device. A host frames each access with an active-low chip select. It moves an instruction byte and then a data byte over a slow serial link, using a shift clock that has no phase relation to the device's system clock. The port reads and writes a small bank of byte registers: a control byte, receive and transmit gain bytes, and a hybrid balance byte. Separate data-in and data-out pins are provided, and the data-out pin carries its own tri-state enable so the two can be tied to one wire outside the device.

The port also owns six general-purpose latch pins. A per-pin direction register decides whether each pin is driven from the latch register or sampled into it. Input levels are captured into the latch register on every framed access, so a host can poll external status lines by reading the latch address. Both a master reset input and the system reset return every register to its default. The defaults leave all latch pins undriven and the channel powered down.

All serial inputs are brought into the system clock domain through synchronizers. Edges of the shift clock and chip select are then detected there, so the design has a single clock.

Top module: `ctl_serial_port`

## Requirements
- R1: Shift clock edges while chip select is high change no state: a later read returns the values held before those edges, and no register output moves.
- R2: A frame is an 8-bit instruction followed by an 8-bit data byte, both MSB first, and `sdi` is sampled on rising `sclk` edges. Instruction bit 0 is 1 for read and 0 for write. Bits 3:1 pick the register: 0 control, 1 direction, 2 latch, 3 receive gain, 4 transmit gain, 5 hybrid balance. Bits 7:4 are ignored. Addresses 6 and 7 read as 0x00, and writes to them change nothing.
- R3: A write takes effect at the rising edge of chip select only if exactly 16 rising `sclk` edges were seen in the frame. Otherwise the frame is discarded.
- R4: On a read, the selected register's 8 bits appear on `sdo` MSB first, changing after falling `sclk` edges, so they can be sampled on rising edges 9 to 16. `sdo_oe` is high only while chip select is low, the instruction is a read, and all 8 instruction bits have arrived.
- R5: `lat_oe[i]` equals direction bit i (1 = drive), and `lat_out` equals the latch register.
- R6: Every frame that reaches its 8th rising edge loads the latch register bits of input-direction pins from `lat_in`. A latch read returns those captured levels for input pins and the stored bits for output pins.
- R7: After reset the control byte is 0x01: bit 0 is power-down = 1, bit 1 is amplifier enable = 0, bit 2 is delayed timing = 0. Both gains are 0x00 (no output), hybrid balance is 0x00 (off), direction is 0 (all inputs, `lat_oe` = 0), and the latch register is 0.
- R8: Holding `mr` high for at least one system clock returns every register to its R7 default and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mr | input | 1 | Master reset, active high |
| sclk | input | 1 | Serial shift clock, asynchronous |
| cs_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Tri-state enable for sdo |
| lat_in | input | 6 | Levels sensed on the latch pins |
| lat_out | output | 6 | Levels to drive on the latch pins |
| lat_oe | output | 6 | Per-pin drive enable |
| ctrl_byte | output | 8 | Control register |
| rx_gain | output | 8 | Receive gain register |
| tx_gain | output | 8 | Transmit gain register |
| hyb_bal | output | 8 | Hybrid balance register |

## Verification
A miscounted bit counter shows up in the first frame after it goes wrong. Either a correct 16-edge write is silently dropped, visible on the register output ports within a few clocks of chip select rising, or the read data comes out shifted by one bit position. A corrupted direction or latch bit is visible at once on `lat_oe` or `lat_out`. A stale input capture only appears when the latch address is next read back. A wrong enable state shows as `sdo_oe` high during a write or while chip select is high, within the same frame.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_DIR   = 3'd1,
    RA_LATCH = 3'd2,
    RA_RXG   = 3'd3,
    RA_TXG   = 3'd4,
    RA_HYB   = 3'd5,
    RA_RSV6  = 3'd6,
    RA_RSV7  = 3'd7
  } reg_addr_e;

  // control byte defaults: power-down set, amplifier off, non-delayed timing
  localparam logic [BYTE_W-1:0] CTRL_DEFAULT = 8'h01;

  function automatic logic addr_writable(input logic [2:0] a);
    return a <= 3'd5;
  endfunction

  function automatic logic [2:0] instr_addr(input logic [BYTE_W-1:0] ins);
    return ins[3:1];
  endfunction

  function automatic logic instr_is_read(input logic [BYTE_W-1:0] ins);
    return ins[0];
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
  import scp_pkg::*;
#(
  parameter int INSTR_BITS = 8,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              instr_valid,
  output logic [2:0]        rd_addr,
  output logic              wr_en,
  output logic [2:0]        wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_INSTR = CNT_W'(INSTR_BITS);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);

  logic sclk_d, csn_d;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise, active;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, out_sh, instr_next;
  logic              is_rd_q;
  logic [2:0]        addr_q;
  logic              sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign sclk_fall  = ~sclk_s & sclk_d;
  assign cs_fall    = ~csn_s & csn_d;
  assign cs_rise    = csn_s & ~csn_d;
  assign active     = ~csn_s;
  assign instr_next = {shreg[BYTE_W-2:0], sdi_s};

  assign instr_valid = active && sclk_rise && !clr && (bit_cnt == CNT_INSTR - 1'b1);
  assign rd_addr     = instr_addr(instr_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      is_rd_q <= 1'b0;
      addr_q  <= '0;
      out_sh  <= '0;
      sdo_q   <= 1'b0;
    end else if (clr) begin
      bit_cnt <= CNT_SAT;
      is_rd_q <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      if (cs_fall) begin
        bit_cnt <= '0;
        is_rd_q <= 1'b0;
      end else if (active && sclk_rise) begin
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        shreg <= instr_next;
      end
      if (instr_valid) begin
        is_rd_q <= instr_is_read(instr_next);
        addr_q  <= instr_addr(instr_next);
        out_sh  <= rd_data;
      end
      if (active && sclk_fall && bit_cnt >= CNT_INSTR && bit_cnt < CNT_FRAME) begin
        sdo_q  <= out_sh[BYTE_W-1];
        out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign wr_en   = cs_rise && !clr && (bit_cnt == CNT_FRAME) && !is_rd_q;
  assign wr_addr = addr_q;
  assign wr_data = shreg;
  assign sdo     = sdo_q;
  assign sdo_oe  = active && is_rd_q && (bit_cnt >= CNT_INSTR);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && !clr) |=> $stable(bit_cnt));

  // R4
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe);

endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
  import scp_pkg::*;
#(
  parameter int LATCH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               instr_valid,
  input  logic [2:0]         rd_addr,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [LATCH_W-1:0] pins_s,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [BYTE_W-1:0]  ctrl_q,
  output logic [BYTE_W-1:0]  rxg_q,
  output logic [BYTE_W-1:0]  txg_q,
  output logic [BYTE_W-1:0]  hyb_q,
  output logic [LATCH_W-1:0] dir_q,
  output logic [LATCH_W-1:0] latch_q
);

  function automatic logic [LATCH_W-1:0] merge_pins(
    input logic [LATCH_W-1:0] held,
    input logic [LATCH_W-1:0] dir,
    input logic [LATCH_W-1:0] pins);
    return (held & dir) | (pins & ~dir);
  endfunction

  function automatic logic [BYTE_W-1:0] widen(input logic [LATCH_W-1:0] v);
    logic [BYTE_W-1:0] t;
    t = '0;
    t[LATCH_W-1:0] = v;
    return t;
  endfunction

  logic [LATCH_W-1:0] latch_view;
  assign latch_view = merge_pins(latch_q, dir_q, pins_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_DEFAULT;
      rxg_q   <= '0;
      txg_q   <= '0;
      hyb_q   <= '0;
      dir_q   <= '0;
      latch_q <= '0;
    end else if (clr) begin
      ctrl_q  <= CTRL_DEFAULT;
      rxg_q   <= '0;
      txg_q   <= '0;
      hyb_q   <= '0;
      dir_q   <= '0;
      latch_q <= '0;
    end else if (wr_en && addr_writable(wr_addr)) begin
      unique case (reg_addr_e'(wr_addr))
        RA_CTRL:  ctrl_q  <= wr_data;
        RA_DIR:   dir_q   <= wr_data[LATCH_W-1:0];
        RA_LATCH: latch_q <= wr_data[LATCH_W-1:0];
        RA_RXG:   rxg_q   <= wr_data;
        RA_TXG:   txg_q   <= wr_data;
        RA_HYB:   hyb_q   <= wr_data;
        default:  ;
      endcase
    end else if (instr_valid) begin
      latch_q <= latch_view;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      RA_CTRL:  rd_data = ctrl_q;
      RA_DIR:   rd_data = widen(dir_q);
      RA_LATCH: rd_data = widen(latch_view);
      RA_RXG:   rd_data = rxg_q;
      RA_TXG:   rd_data = txg_q;
      RA_HYB:   rd_data = hyb_q;
      default:  rd_data = '0;
    endcase
  end

  // R3
  dir_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && wr_addr == RA_DIR) |=> dir_q == $past(wr_data[LATCH_W-1:0]));

  // R8
  mr_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctrl_q == CTRL_DEFAULT && rxg_q == '0 && txg_q == '0 &&
             hyb_q == '0 && dir_q == '0 && latch_q == '0));

  // R6
  pin_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !wr_en && !clr) |=> ((latch_q & ~dir_q) == $past(pins_s & ~dir_q)));

endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import scp_pkg::*;
#(
  parameter int LATCH_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mr,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdo_oe,
  input  logic [LATCH_W-1:0] lat_in,
  output logic [LATCH_W-1:0] lat_out,
  output logic [LATCH_W-1:0] lat_oe,
  output logic [BYTE_W-1:0]  ctrl_byte,
  output logic [BYTE_W-1:0]  rx_gain,
  output logic [BYTE_W-1:0]  tx_gain,
  output logic [BYTE_W-1:0]  hyb_bal
);
  logic sclk_s, csn_s, sdi_s;
  logic [LATCH_W-1:0] pins_s;
  logic instr_valid, wr_en;
  logic [2:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic [LATCH_W-1:0] dir_q, latch_q;

  scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync_ser (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, cs_n, sdi}), .q({sclk_s, csn_s, sdi_s}));

  scp_sync #(.W(LATCH_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pins (
    .clk(clk), .rst_n(rst_n), .d(lat_in), .q(pins_s));

  scp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clr(mr),
    .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .instr_valid(instr_valid), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe));

  scp_regbank #(.LATCH_W(LATCH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(mr),
    .instr_valid(instr_valid), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pins_s(pins_s), .rd_data(rd_data),
    .ctrl_q(ctrl_byte), .rxg_q(rx_gain), .txg_q(tx_gain), .hyb_q(hyb_bal),
    .dir_q(dir_q), .latch_q(latch_q));

  assign lat_oe  = dir_q;
  assign lat_out = latch_q;

  // R5
  undriven_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> lat_oe == '0);

endmodule

// File: tb/sim_ctl_serial_port.sv
`timescale 1ns/1ps
module sim_ctl_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mr = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [5:0] lat_in = '0, lat_out, lat_oe;
  logic [7:0] ctrl_byte, rx_gain, tx_gain, hyb_bal;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] m_ctrl, m_rx, m_tx, m_hyb;
  logic [5:0] m_dir, m_lat;

  always #2.5 clk = ~clk;

  ctl_serial_port u0 (.*);

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [5:0] pins);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return {2'b00, m_dir};
      3'd2: return {2'b00, (m_lat & m_dir) | (pins & ~m_dir)};
      3'd3: return m_rx;
      3'd4: return m_tx;
      3'd5: return m_hyb;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_defaults();
    m_ctrl = 8'h01; m_rx = 0; m_tx = 0; m_hyb = 0; m_dir = 0; m_lat = 0;
  endtask

  // apply one frame to the model; returns the expected read value
  task automatic model_frame(input logic [7:0] ins, input logic [7:0] dat,
                             input int nbits, output logic [7:0] rexp);
    logic [2:0] a;
    a = ins[3:1];
    rexp = exp_read(a, lat_in);
    if (nbits >= 8) m_lat = (m_lat & m_dir) | (lat_in & ~m_dir);
    if (nbits == 16 && !ins[0]) begin
      case (a)
        3'd0: m_ctrl = dat;
        3'd1: m_dir = dat[5:0];
        3'd2: m_lat = dat[5:0];
        3'd3: m_rx = dat;
        3'd4: m_tx = dat;
        3'd5: m_hyb = dat;
        default: ;
      endcase
    end
  endtask

  task automatic xfer(input logic [7:0] ins, input logic [7:0] dat, input int nbits,
                      output logic [7:0] rdv, output logic oe_mid);
    rdv = '0; oe_mid = 1'b0;
    cs_n = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? ins[7-i] : ((i < 16) ? dat[15-i] : 1'b0);
      wait_clk(6);
      if (i >= 8 && i < 16) rdv[15-i] = sdo;
      if (i == 12) oe_mid = sdo_oe;
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(2);
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_ports(input string req);
    chk(req, ctrl_byte, m_ctrl);
    chk(req, rx_gain, m_rx);
    chk(req, tx_gain, m_tx);
    chk(req, hyb_bal, m_hyb);
    chk(req, {2'b00, lat_oe}, {2'b00, m_dir});
    chk(req, {2'b00, lat_out}, {2'b00, m_lat});
  endtask

  task automatic frame(input logic [7:0] ins, input logic [7:0] dat, input int nbits,
                       input string req);
    logic [7:0] rexp, rdv;
    logic oe;
    model_frame(ins, dat, nbits, rexp);
    xfer(ins, dat, nbits, rdv, oe);
    if (nbits == 16) begin
      chk({req, " R4 oe"}, {7'd0, oe}, {7'd0, ins[0]});
      if (ins[0]) chk({req, " R4 rdata"}, rdv, rexp);
    end
    chk({req, " R4 idle oe"}, {7'd0, sdo_oe}, 8'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_defaults();
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R7 defaults
    check_ports("R7");
    chk("R7 oe", {7'd0, sdo_oe}, 8'd0);
    frame(8'h01, 8'h00, 16, "R7 ctrl read");

    // R5 direction then latch drive
    frame({4'h0, 3'd1, 1'b0}, 8'h2A, 16, "R5");
    check_ports("R5 dir");
    frame({4'h0, 3'd2, 1'b0}, 8'h3F, 16, "R5");
    check_ports("R5 lat");

    // R6 input capture on read of the latch register
    lat_in = 6'b010101;
    wait_clk(8);
    frame({4'h0, 3'd2, 1'b1}, 8'h00, 16, "R6");
    check_ports("R6");
    lat_in = 6'b101010;
    wait_clk(8);
    frame({4'hF, 3'd3, 1'b0}, 8'h5C, 16, "R6 R2 upper bits");
    check_ports("R6 capture on write");

    // R1 sclk activity with chip select high
    sdi = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sclk = 1'b1; wait_clk(8); sclk = 1'b0; wait_clk(8);
    end
    check_ports("R1");
    frame({4'h0, 3'd3, 1'b1}, 8'h00, 16, "R1 readback");

    // R3 wrong bit counts
    frame({4'h0, 3'd4, 1'b0}, 8'hA7, 15, "R3 short");
    check_ports("R3 short");
    frame({4'h0, 3'd4, 1'b0}, 8'hA7, 17, "R3 long");
    check_ports("R3 long");
    frame({4'h0, 3'd4, 1'b0}, 8'hA7, 5, "R3 tiny");
    check_ports("R3 tiny");

    // R2 reserved addresses
    frame({4'h0, 3'd7, 1'b0}, 8'hFF, 16, "R2 rsv write");
    check_ports("R2 rsv write");
    frame({4'h0, 3'd6, 1'b1}, 8'h00, 16, "R2 rsv read");

    // R8 master reset
    frame({4'h0, 3'd0, 1'b0}, 8'hE6, 16, "R8 setup");
    frame({4'h0, 3'd5, 1'b0}, 8'h99, 16, "R8 setup");
    mr = 1'b1; wait_clk(2); mr = 1'b0; wait_clk(4);
    model_defaults();
    check_ports("R8");

    // random mix
    for (int n = 0; n < 250; n++) begin
      logic [7:0] ins, dat;
      int nb, pick;
      ins = 8'($urandom);
      dat = 8'($urandom);
      pick = int'($urandom_range(0, 19));
      nb = (pick == 0) ? 12 : (pick == 1) ? 17 : (pick == 2) ? 6 : 16;
      if ($urandom_range(0, 3) == 0) begin
        lat_in = 6'($urandom);
        wait_clk(8);
      end
      if ($urandom_range(0, 60) == 0) begin
        mr = 1'b1; wait_clk(1); mr = 1'b0; wait_clk(4);
        model_defaults();
        check_ports("R8 random");
      end
      frame(ins, dat, nb, "R2 random");
      check_ports("R3 R5 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule